// File: doc/BRIEF.md
# UART Transmit Holding Queue with Free-Space Trigger

This block is the buffer that sits between a host's transmit writes and a UART's transmit shift register. The host pushes bytes through a write strobe. The shift register takes them one at a time, oldest first, over a valid/ready pop port. In normal operation the queue holds up to 64 bytes. When queueing is switched off, the same storage is still used, but it holds only one byte at a time. A byte offered while the queue is full is dropped, unless a pop in the same cycle makes room for it.

The block also holds the transmit half of the FIFO control register. That half has two parts: a self-clearing flush command and a 2-bit trigger-level code. The trigger output reports whether enough free slots exist for the host to write a burst. It compares free space, not stored bytes, against a threshold. The code can be changed only while an enhanced-function enable input is high; at other times, writes to it are ignored.

Top module: `uart_txq`

## Requirements
- R1: Bytes leave on `pop_data` in the order they were accepted. `pop_valid` is 1 whenever `level` (the number of stored bytes) is non-zero. A pop happens on a clock edge where `pop_valid` and `pop_ready` are both 1. An accepted push or pop changes `level` at that edge.
- R2: With `fifo_en`=1 the queue holds 64 bytes, and `full` is 1 exactly when `level` is 64. A write on a full queue with no pop in the same cycle is discarded, and `level` and the stored bytes stay unchanged.
- R3: With `fifo_en`=0 the depth is one byte. A written byte is still stored, and it shows on `pop_valid`/`pop_data` after the next edge. `full` is 1 once one byte is held, and further writes without a pop are discarded.
- R4: A write and a pop in the same cycle on a full queue are both accepted. `level` stays at the depth, and the new byte is placed behind the rest with nothing lost.
- R5: A control write (`ctl_we`=1) with `ctl_flush`=1 empties the queue at that edge, so `level` is 0 afterwards. A push or pop in the same cycle is dropped. The flush bit is not stored: a later control write with `ctl_flush`=0 empties nothing.
- R6: `space_trig` is 1 exactly when (64 − `level`) is greater than or equal to the threshold picked by the trigger code. The codes are 2'b00 → 8, 2'b01 → 16, 2'b10 → 32 and 2'b11 → 56 free slots.
- R7: A control write loads `ctl_trig` into the trigger code only while `enh_en`=1. If `enh_en`=0, the code keeps its old value and `space_trig` behaves as before.
- R8: After reset `level` is 0, `pop_valid` and `full` are 0, `empty` is 1, the trigger code is 2'b00 and `space_trig` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: 64-byte queueing; 0: single-byte holding |
| enh_en | input | 1 | Enhanced-function enable; allows trigger-code updates |
| ctl_we | input | 1 | Control register write strobe |
| ctl_flush | input | 1 | Flush command bit of the control write |
| ctl_trig | input | 2 | Trigger code field of the control write |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| pop_valid | output | 1 | A byte is available to the shift register |
| pop_data | output | 8 | Oldest stored byte |
| pop_ready | input | 1 | Shift register takes the byte at this edge |
| level | output | 7 | Number of stored bytes, 0 to 64 |
| full | output | 1 | No room at the current depth |
| empty | output | 1 | Nothing stored |
| space_trig | output | 1 | Free space is at or above the selected threshold |

## Verification
The bench fills the queue to exactly 64 bytes and keeps writing. A design with an off-by-one in the full test would take a 65th byte, or would refuse the 64th. It pushes and pops together on a full queue, both with queueing on and with the single-byte depth. A design that checks room before crediting the pop would lose the byte there. Locked trigger writes land at a level where the old and new thresholds give opposite results, so a leaky write protect shows up on `space_trig`. Flushes that coincide with pushes and pops, and control writes without the flush bit, expose a flush that is latched or that lets a concurrent byte through.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  typedef enum logic [1:0] {
    TRIG_EIGHTH   = 2'b00,
    TRIG_QUARTER  = 2'b01,
    TRIG_HALF     = 2'b10,
    TRIG_7EIGHTHS = 2'b11
  } trig_code_e;

  // Free-space threshold as a fraction of the depth (8/16/32/56 at depth 64).
  function automatic int trig_threshold(input trig_code_e code, input int depth);
    case (code)
      TRIG_EIGHTH:   trig_threshold = depth / 8;
      TRIG_QUARTER:  trig_threshold = depth / 4;
      TRIG_HALF:     trig_threshold = depth / 2;
      default:       trig_threshold = (depth * 7) / 8;
    endcase
  endfunction

endpackage

// File: rtl/uart_txq_ctl.sv
module uart_txq_ctl
  import uart_txq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enh_en,
  input  logic       ctl_we,
  input  logic       ctl_flush,
  input  logic [1:0] ctl_trig,
  output logic       flush,
  output trig_code_e trig_code
);

  trig_code_e trig_q;
  trig_code_e trig_d;
  logic       trig_ld;

  // Flush is a command, never stored: it acts only in the cycle of the write.
  assign flush   = ctl_we & ctl_flush;
  assign trig_ld = ctl_we & enh_en;

  always_comb begin
    trig_d = trig_q;
    if (trig_ld) trig_d = trig_code_e'(ctl_trig);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= TRIG_EIGHTH;
    else        trig_q <= trig_d;
  end

  assign trig_code = trig_q;

  // R7: a write while the enhanced enable is low leaves the code untouched
  assert_trig_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !enh_en) |=> $stable(trig_q));

endmodule

// File: rtl/uart_txq_buf.sv
module uart_txq_buf #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop_ready,
  output logic             pop_valid,
  output logic [WIDTH-1:0] pop_data,
  output logic [CW-1:0]    count,
  output logic             full
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    count_q, count_d;
  logic [CW-1:0]    cap;
  logic             full_w;
  logic             pop_do;
  logic             push_do;

  // Disabled queueing still routes the byte through slot storage, depth one.
  assign cap     = fifo_en ? DEPTH_C : ONE_C;
  assign full_w  = (count_q >= cap);
  assign pop_do  = (count_q != '0) && pop_ready && !flush;
  assign push_do = wr_en && !flush && (!full_w || pop_do);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_do) wr_ptr_d = wr_ptr_q + AW'(1);
      if (pop_do)  rd_ptr_d = rd_ptr_q + AW'(1);
      case ({push_do, pop_do})
        2'b10:   count_d = count_q + ONE_C;
        2'b01:   count_d = count_q - ONE_C;
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_do) mem[wr_ptr_q] <= wr_data;
  end

  assign pop_valid = (count_q != '0);
  assign pop_data  = mem[rd_ptr_q];
  assign count     = count_q;
  assign full      = full_w;

  // R2: occupancy never exceeds the physical depth
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= DEPTH_C);

  // R2: a write into a full queue without a pop changes nothing
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full_w && wr_en && !pop_ready && !flush) |=> (count_q == $past(count_q)));

  // R3: single-byte depth holds at one while no pop happens
  assert_single_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && count_q == ONE_C && !pop_ready && !flush) |=> (count_q == ONE_C));

  // R4: push and pop together on a full queue keep the level
  assert_full_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_w && wr_en && pop_ready && !flush) |=> (count_q == $past(count_q)));

  // R5: a flush leaves the queue empty
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0));

endmodule

// File: rtl/uart_txq_trig.sv
module uart_txq_trig
  import uart_txq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  trig_code_e    trig_code,
  output logic          space_trig
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] free_slots;
  logic [CW-1:0] thresh;

  assign free_slots = DEPTH_C - count;
  assign thresh     = CW'(trig_threshold(trig_code, DEPTH));
  assign space_trig = (free_slots >= thresh);

endmodule

// File: rtl/uart_txq.sv
module uart_txq
  import uart_txq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             enh_en,
  input  logic             ctl_we,
  input  logic             ctl_flush,
  input  logic [1:0]       ctl_trig,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             pop_valid,
  output logic [WIDTH-1:0] pop_data,
  input  logic             pop_ready,
  output logic [CW-1:0]    level,
  output logic             full,
  output logic             empty,
  output logic             space_trig
);

  logic       flush;
  trig_code_e trig_code;

  uart_txq_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enh_en    (enh_en),
    .ctl_we    (ctl_we),
    .ctl_flush (ctl_flush),
    .ctl_trig  (ctl_trig),
    .flush     (flush),
    .trig_code (trig_code)
  );

  uart_txq_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .flush     (flush),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .pop_ready (pop_ready),
    .pop_valid (pop_valid),
    .pop_data  (pop_data),
    .count     (level),
    .full      (full)
  );

  uart_txq_trig #(.DEPTH(DEPTH)) u_trig (
    .count      (level),
    .trig_code  (trig_code),
    .space_trig (space_trig)
  );

  assign empty = ~pop_valid;

  // R6/R8: an empty queue always has room for any threshold
  assert_empty_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> space_trig);

  // R1: the pop port offers data exactly when something is stored
  assert_valid_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid == (level != '0));

endmodule

// File: tb/tb_uart_txq.sv
module tb_uart_txq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en, enh_en, ctl_we, ctl_flush, wr_en, pop_ready;
  logic [1:0] ctl_trig;
  logic [7:0] wr_data;
  logic       pop_valid, full, empty, space_trig;
  logic [7:0] pop_data;
  logic [6:0] level;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  byte unsigned q[$];
  int           m_trig;

  always #10 clk = ~clk;

  uart_txq dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .enh_en(enh_en),
    .ctl_we(ctl_we), .ctl_flush(ctl_flush), .ctl_trig(ctl_trig),
    .wr_en(wr_en), .wr_data(wr_data), .pop_valid(pop_valid),
    .pop_data(pop_data), .pop_ready(pop_ready), .level(level),
    .full(full), .empty(empty), .space_trig(space_trig)
  );

  function automatic int thr(input int code);
    case (code)
      0: thr = 8;
      1: thr = 16;
      2: thr = 32;
      default: thr = 56;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every output against the behavioural model (called at negedge).
  task automatic compare_all(input string tag);
    int cap = fifo_en ? 64 : 1;
    chk({tag, " R1 level"}, level, q.size());
    chk({tag, " R1 pop_valid"}, pop_valid, q.size() != 0);
    chk({tag, " R8 empty"}, empty, q.size() == 0);
    chk({tag, " R2/R3 full"}, full, q.size() >= cap);
    chk({tag, " R6/R7 space_trig"}, space_trig, (64 - q.size()) >= thr(m_trig));
    if (q.size() != 0) chk({tag, " R1/R4 pop_data"}, pop_data, q[0]);
  endtask

  // Drive one cycle of inputs, advance the model, compare after the edge.
  task automatic step(input bit en, input bit enh, input bit we, input bit fl,
                      input int tc, input bit wr, input int d, input bit rdy,
                      input string tag);
    bit pop, push, is_full;
    fifo_en = en; enh_en = enh; ctl_we = we; ctl_flush = fl;
    ctl_trig = 2'(tc); wr_en = wr; wr_data = 8'(d); pop_ready = rdy;
    is_full = q.size() >= (en ? 64 : 1);
    pop  = (q.size() != 0) && rdy;
    push = wr && (!is_full || pop);
    if (we && fl) q.delete();
    else begin
      if (pop) void'(q.pop_front());
      if (push) q.push_back(byte'(d));
    end
    if (we && enh) m_trig = tc;
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fifo_en = 1; enh_en = 0; ctl_we = 0; ctl_flush = 0; ctl_trig = 0;
    wr_en = 0; wr_data = 0; pop_ready = 0;
    m_trig = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk("R8 reset level", level, 0);
    chk("R8 reset empty", empty, 1);
    chk("R8 reset space_trig", space_trig, 1);
    compare_all("reset");

    // R6: select 56-free threshold, fill to 64 and watch the trigger drop
    step(1, 1, 1, 0, 3, 0, 0, 0, "R6 set code 11");
    for (int i = 0; i < 64; i++) step(1, 0, 0, 0, 0, 1, i + 1, 0, "R1 fill");
    chk("R2 full at 64", full, 1);
    // R2: overfill is discarded
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 1, 200 + i, 0, "R2 overfill");
    chk("R2 level held", level, 64);
    // R4: push+pop on full
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 1, 100 + i, 1, "R4 swap");
    chk("R4 level after swaps", level, 64);
    // drain to 50 stored (14 free)
    for (int i = 0; i < 14; i++) step(1, 0, 0, 0, 0, 0, 0, 1, "R1 drain");
    // R7: locked write of code 00 must not raise the trigger
    step(1, 0, 1, 0, 0, 0, 0, 0, "R7 locked");
    chk("R7 locked trig", space_trig, 0);
    // R7: unlocked write of code 00 raises it
    step(1, 1, 1, 0, 0, 0, 0, 0, "R7 unlocked");
    chk("R7 unlocked trig", space_trig, 1);
    // R6: every code at this level
    for (int c = 0; c < 4; c++) step(1, 1, 1, 0, c, 0, 0, 0, "R6 code sweep");
    // R5: flush with concurrent push and pop
    step(1, 0, 1, 1, 0, 1, 77, 1, "R5 flush");
    chk("R5 level after flush", level, 0);
    // R5: non-flush control write does not flush
    step(1, 0, 0, 0, 0, 1, 5, 0, "R5 refill");
    step(1, 0, 1, 0, 0, 0, 0, 0, "R5 no-flush write");
    chk("R5 not stored", level, 1);
    step(1, 0, 1, 1, 0, 0, 0, 0, "R5 flush2");

    // R3: disabled mode, depth one
    step(0, 0, 0, 0, 0, 1, 9, 0, "R3 write");
    chk("R3 stored", pop_valid, 1);
    chk("R3 full", full, 1);
    step(0, 0, 0, 0, 0, 1, 10, 0, "R3 drop");
    chk("R3 kept first", pop_data, 9);
    step(0, 0, 0, 0, 0, 1, 11, 1, "R3/R4 swap");
    chk("R4 single swap data", pop_data, 11);
    step(0, 0, 0, 0, 0, 0, 0, 1, "R3 drain");

    // Mixed random traffic in both modes
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      bit en = (i / 500) % 3 != 2;
      step(en, $urandom_range(0, 1), r < 3, r < 1, $urandom_range(0, 3),
           $urandom_range(0, 99) < 60, $urandom_range(0, 255),
           $urandom_range(0, 99) < ((i / 250) % 2 ? 70 : 35), "R1 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule